// File: doc/BRIEF.md
# Center-Aligned Four-Channel PWM Timer

This block is a motor-control timer built around one 16-bit counter shared by four compare channels. The counter runs in count-up, count-down, or one of three center-aligned modes in which it climbs from zero to the period value and falls back again. Each channel compares the count against its own compare value and drives a PWM pin. The rule for that comparison depends on the count direction and on one of two PWM rules that the channel selects. A per-channel polarity bit inverts the pin. Two channels with equal compare values and opposite polarity therefore give a complementary pair, which suits a locked-antiphase bridge drive.

Compare values can be buffered in a shadow register and moved into use only at a counter turnaround. Both halves of a pair then switch in the same cycle, even when software writes them one after the other. Each channel also keeps a sticky compare flag. The center-aligned variant picks which count direction may set that flag. All settings are loaded through a single-cycle write port.

Top module: `ctr_pwm_timer`

## Requirements
- R1: After reset all pins are low, all flags are clear, the update pulse is low and the counter is stopped with period 0xFFFF, prescaler 0 and mode up.
- R2: With prescaler value P (address 2), the counter advances once every P+1 clocks, so with period N in up mode the update pulse repeats every (N+1)(P+1) clocks.
- R3: Register 0 bits [2:0] select the mode (0 up, 1 down, 2/3/4 center variants A/B/C) and bit 3 runs the counter. Period N is at address 1. In up mode the count goes 0..N, wraps to 0 and pulses `upd_evt` on the wrapping tick. In down mode it goes N..0, reloads N and pulses on the reloading tick. Both repeat every N+1 ticks.
- R4: In the center modes the count rises 0..N, then falls N-1..0. `upd_evt` pulses at the top and at the bottom, every N ticks, and the direction reverses there.
- R5: Channel config at address 8+i uses bit 0 for the PWM rule, bit 1 for polarity (1 = active low), bit 2 for preload and bit 3 for output enable. Compare value C is at address 4+i. With rule 0, the channel is active while count < C when rising and while count <= C when falling. The pin shows the level for the previous cycle's count.
- R6: With rule 1, the channel is active while count >= C when rising and while count > C when falling.
- R7: An active-low channel drives the inverse of the active level. Two enabled channels with the same rule and compare value but opposite polarity give complementary pins.
- R8: A flag sets on a counter tick whose count equals the compare value. In center variant A this happens only while falling, in variant B only while rising, and in variant C and the edge modes in either direction.
- R9: A flag stays set until bit i is written as 1 to address 3. If that clear falls in the same cycle as a new set, the flag stays set.
- R10: With preload on, a compare write goes to a shadow and takes effect only at an update pulse. A write in the same cycle as the pulse is used at once. With preload off, the write takes effect on the next cycle.
- R11: With output enable at 0, the pin sits at the inactive level, which equals the polarity bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 16 | Register write data |
| pwm_out | output | 4 | PWM pins, one per channel |
| cmp_flag | output | 4 | Sticky compare flags, one per channel |
| upd_evt | output | 1 | Update pulse at each wrap, reload or turnaround |

## Verification
A compare flag can be set by a counter match in the same cycle that software writes 1 to clear it. The bench provokes this by watching its own model of the counter and issuing the clear write exactly in the cycle before the matching edge. It then judges that the flag reads 1 afterwards, and that a later clear with no match pending leaves it at 0. A second collision, a compare write landing on an update pulse, is covered by random writes checked against the bench model.

// File: rtl/ctr_pwm_pkg.sv
package ctr_pwm_pkg;
  typedef enum logic [2:0] {
    CM_UP   = 3'd0,
    CM_DOWN = 3'd1,
    CM_CTR1 = 3'd2,
    CM_CTR2 = 3'd3,
    CM_CTR3 = 3'd4
  } cnt_mode_e;

  // bit 3 output enable, bit 2 preload, bit 1 active low, bit 0 second rule
  typedef struct packed {
    logic oen;
    logic preload;
    logic pol_low;
    logic pwm2;
  } ch_cfg_t;

  localparam int CFG_W         = 4;
  localparam int ADDR_CTRL     = 0;
  localparam int ADDR_PERIOD   = 1;
  localparam int ADDR_PSC      = 2;
  localparam int ADDR_CLR      = 3;
  localparam int ADDR_CMP_BASE = 4;
endpackage

// File: rtl/ctr_pwm_regs.sv
module ctr_pwm_regs
  import ctr_pwm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int N_CH   = 4,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output cnt_mode_e         mode_o,
  output logic              en_o,
  output logic [CNT_W-1:0]  period_o,
  output logic [CNT_W-1:0]  psc_o,
  output logic [N_CH-1:0]   cmp_wr_o,
  output logic [N_CH-1:0]   cfg_wr_o,
  output logic [N_CH-1:0]   clr_o
);
  localparam int CFG_BASE = ADDR_CMP_BASE + N_CH;

  cnt_mode_e        mode_q, mode_d;
  logic             en_q, en_d;
  logic [CNT_W-1:0] period_q, period_d;
  logic [CNT_W-1:0] psc_q, psc_d;

  logic wr_ctrl, wr_period, wr_psc, wr_clr;

  assign wr_ctrl   = wr_en && (wr_addr == ADDR_W'(ADDR_CTRL));
  assign wr_period = wr_en && (wr_addr == ADDR_W'(ADDR_PERIOD));
  assign wr_psc    = wr_en && (wr_addr == ADDR_W'(ADDR_PSC));
  assign wr_clr    = wr_en && (wr_addr == ADDR_W'(ADDR_CLR));

  always_comb begin
    mode_d   = mode_q;
    en_d     = en_q;
    period_d = period_q;
    psc_d    = psc_q;
    if (wr_ctrl) begin
      en_d = wr_data[3];
      if (wr_data[2:0] > 3'd4) mode_d = CM_UP;
      else                     mode_d = cnt_mode_e'(wr_data[2:0]);
    end
    if (wr_period) period_d = wr_data;
    if (wr_psc)    psc_d    = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= CM_UP;
      en_q     <= 1'b0;
      period_q <= '1;
      psc_q    <= '0;
    end else begin
      mode_q   <= mode_d;
      en_q     <= en_d;
      period_q <= period_d;
      psc_q    <= psc_d;
    end
  end

  for (genvar i = 0; i < N_CH; i++) begin : g_strobe
    assign cmp_wr_o[i] = wr_en && (wr_addr == ADDR_W'(ADDR_CMP_BASE + i));
    assign cfg_wr_o[i] = wr_en && (wr_addr == ADDR_W'(CFG_BASE + i));
    assign clr_o[i]    = wr_clr && wr_data[i];
  end

  assign mode_o   = mode_q;
  assign en_o     = en_q;
  assign period_o = period_q;
  assign psc_o    = psc_q;
endmodule

// File: rtl/ctr_pwm_counter.sv
module ctr_pwm_counter
  import ctr_pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cnt_mode_e        mode_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] period_i,
  input  logic [CNT_W-1:0] psc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             dir_down_o,
  output logic             tick_o,
  output logic             upd_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] psc_q, psc_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             dir_q, dir_d;
  logic             tick, upd, center;

  assign center = (mode_i == CM_CTR1) || (mode_i == CM_CTR2) || (mode_i == CM_CTR3);

  always_comb begin
    psc_d = psc_q;
    cnt_d = cnt_q;
    dir_d = dir_q;
    tick  = 1'b0;
    upd   = 1'b0;
    if (en_i) begin
      if (psc_q >= psc_i) begin
        tick  = 1'b1;
        psc_d = '0;
      end else begin
        psc_d = psc_q + ONE;
      end
    end
    if (tick) begin
      if (mode_i == CM_DOWN) begin
        dir_d = 1'b1;
        if (cnt_q == '0) begin
          cnt_d = period_i;
          upd   = 1'b1;
        end else begin
          cnt_d = cnt_q - ONE;
        end
      end else if (center) begin
        if (!dir_q) begin
          if (cnt_q >= period_i) begin
            upd   = 1'b1;
            dir_d = 1'b1;
            cnt_d = (period_i == '0) ? '0 : period_i - ONE;
          end else begin
            cnt_d = cnt_q + ONE;
          end
        end else begin
          if (cnt_q == '0) begin
            upd   = 1'b1;
            dir_d = 1'b0;
            cnt_d = (period_i == '0) ? '0 : ONE;
          end else begin
            cnt_d = cnt_q - ONE;
          end
        end
      end else begin
        dir_d = 1'b0;
        if (cnt_q >= period_i) begin
          cnt_d = '0;
          upd   = 1'b1;
        end else begin
          cnt_d = cnt_q + ONE;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_q <= '0;
      cnt_q <= '0;
      dir_q <= 1'b0;
    end else begin
      psc_q <= psc_d;
      cnt_q <= cnt_d;
      dir_q <= dir_d;
    end
  end

  assign cnt_o      = cnt_q;
  assign dir_down_o = dir_q;
  assign tick_o     = tick;
  assign upd_o      = upd;

  // R2
  hold_without_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q));

  // R3
  up_wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && mode_i == CM_UP) |=> (cnt_q == '0));

  // R4
  center_turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && center) |=> (dir_q != $past(dir_q)));
endmodule

// File: rtl/ctr_pwm_channel.sv
module ctr_pwm_channel
  import ctr_pwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             dir_down_i,
  input  logic             tick_i,
  input  logic             upd_i,
  input  cnt_mode_e        mode_i,
  input  logic             cmp_wr_i,
  input  logic             cfg_wr_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic             pwm_o,
  output logic             flag_o
);
  ch_cfg_t          cfg_q, cfg_d;
  logic [CNT_W-1:0] shadow_q, shadow_d;
  logic [CNT_W-1:0] act_q, act_d;
  logic             flag_q, flag_d;
  logic             pwm_q, pwm_d;
  logic             active, dir_ok, flag_set;

  always_comb begin
    if (!dir_down_i) active = cfg_q.pwm2 ? (cnt_i >= act_q) : (cnt_i < act_q);
    else             active = cfg_q.pwm2 ? (cnt_i > act_q)  : (cnt_i <= act_q);
  end

  always_comb begin
    case (mode_i)
      CM_CTR1: dir_ok = dir_down_i;
      CM_CTR2: dir_ok = !dir_down_i;
      default: dir_ok = 1'b1;
    endcase
  end

  assign flag_set = tick_i && dir_ok && (cnt_i == act_q);

  always_comb begin
    cfg_d    = cfg_wr_i ? ch_cfg_t'(wr_data_i[CFG_W-1:0]) : cfg_q;
    shadow_d = cmp_wr_i ? wr_data_i : shadow_q;
    act_d    = (!cfg_q.preload || upd_i) ? shadow_d : act_q;
    flag_d   = flag_set || (flag_q && !clr_i);
    pwm_d    = cfg_q.oen ? (active ^ cfg_q.pol_low) : cfg_q.pol_low;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      shadow_q <= '0;
      act_q    <= '0;
      flag_q   <= 1'b0;
      pwm_q    <= 1'b0;
    end else begin
      cfg_q    <= cfg_d;
      shadow_q <= shadow_d;
      act_q    <= act_d;
      flag_q   <= flag_d;
      pwm_q    <= pwm_d;
    end
  end

  assign pwm_o  = pwm_q;
  assign flag_o = flag_q;

  // R9
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_set && clr_i) |=> flag_q);

  // R10
  preload_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.preload && !upd_i) |=> $stable(act_q));

  // R8
  ctr_a_falling_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(flag_q) && $past(mode_i == CM_CTR1)) |-> $past(dir_down_i));
endmodule

// File: rtl/ctr_pwm_timer.sv
module ctr_pwm_timer
  import ctr_pwm_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int N_CH   = 4,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output logic [N_CH-1:0]   pwm_out,
  output logic [N_CH-1:0]   cmp_flag,
  output logic              upd_evt
);
  logic [1:0]       rst_sync_q;
  logic             rst_core_n;
  cnt_mode_e        mode;
  logic             en;
  logic [CNT_W-1:0] period, psc, cnt;
  logic [N_CH-1:0]  cmp_wr, cfg_wr, clr;
  logic             dir_down, tick, upd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  ctr_pwm_regs #(.CNT_W(CNT_W), .N_CH(N_CH), .ADDR_W(ADDR_W)) i_regs (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .mode_o   (mode),
    .en_o     (en),
    .period_o (period),
    .psc_o    (psc),
    .cmp_wr_o (cmp_wr),
    .cfg_wr_o (cfg_wr),
    .clr_o    (clr)
  );

  ctr_pwm_counter #(.CNT_W(CNT_W)) i_counter (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .mode_i     (mode),
    .en_i       (en),
    .period_i   (period),
    .psc_i      (psc),
    .cnt_o      (cnt),
    .dir_down_o (dir_down),
    .tick_o     (tick),
    .upd_o      (upd)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    ctr_pwm_channel #(.CNT_W(CNT_W)) i_ch (
      .clk        (clk),
      .rst_n      (rst_core_n),
      .cnt_i      (cnt),
      .dir_down_i (dir_down),
      .tick_i     (tick),
      .upd_i      (upd),
      .mode_i     (mode),
      .cmp_wr_i   (cmp_wr[i]),
      .cfg_wr_i   (cfg_wr[i]),
      .clr_i      (clr[i]),
      .wr_data_i  (wr_data),
      .pwm_o      (pwm_out[i]),
      .flag_o     (cmp_flag[i])
    );
  end

  assign upd_evt = upd;
endmodule

// File: tb/test_ctr_pwm_timer.sv
module test_ctr_pwm_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [3:0]  pwm_out, cmp_flag;
  logic        upd_evt;

  int n_chk = 0;
  int n_fail = 0;
  bit pair01 = 0;
  bit pair23 = 0;

  always #10 clk = ~clk;

  ctr_pwm_timer i_ctr_pwm_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pwm_out(pwm_out), .cmp_flag(cmp_flag), .upd_evt(upd_evt)
  );

  // reference model, built from the requirements
  int          m_mode, m_en, m_psc, m_per, m_pcnt, m_cnt, m_dir;
  logic [3:0]  m_cfg [4];
  int          m_sh [4];
  int          m_act [4];
  bit          m_flag [4];
  bit          m_pwm [4];
  logic [1:0]  m_sync;

  task automatic model_reset();
    m_mode = 0; m_en = 0; m_psc = 0; m_per = 16'hFFFF;
    m_pcnt = 0; m_cnt = 0; m_dir = 0;
    for (int i = 0; i < 4; i++) begin
      m_cfg[i] = '0; m_sh[i] = 0; m_act[i] = 0; m_flag[i] = 0; m_pwm[i] = 0;
    end
  endtask

  function automatic bit m_tick();
    return (m_en != 0) && (m_pcnt >= m_psc);
  endfunction

  function automatic bit m_upd();
    if (!m_tick()) return 0;
    if (m_mode == 0) return m_cnt >= m_per;
    if (m_mode == 1) return m_cnt == 0;
    return (m_dir == 0) ? (m_cnt >= m_per) : (m_cnt == 0);
  endfunction

  task automatic model_step();
    bit t, u, act, ok, set, clr;
    int ncnt, ndir, npc, nsh;
    t = m_tick();
    u = m_upd();
    npc = (m_en == 0) ? m_pcnt : (t ? 0 : m_pcnt + 1);
    ncnt = m_cnt; ndir = m_dir;
    if (t) begin
      if (m_mode == 1) begin
        ndir = 1; ncnt = (m_cnt == 0) ? m_per : m_cnt - 1;
      end else if (m_mode >= 2) begin
        if (m_dir == 0) begin
          if (m_cnt >= m_per) begin ndir = 1; ncnt = (m_per == 0) ? 0 : m_per - 1; end
          else ncnt = m_cnt + 1;
        end else begin
          if (m_cnt == 0) begin ndir = 0; ncnt = (m_per == 0) ? 0 : 1; end
          else ncnt = m_cnt - 1;
        end
      end else begin
        ndir = 0; ncnt = (m_cnt >= m_per) ? 0 : m_cnt + 1;
      end
    end
    for (int i = 0; i < 4; i++) begin
      if (m_dir == 0) act = m_cfg[i][0] ? (m_cnt >= m_act[i]) : (m_cnt < m_act[i]);
      else            act = m_cfg[i][0] ? (m_cnt > m_act[i])  : (m_cnt <= m_act[i]);
      m_pwm[i] = m_cfg[i][3] ? (act ^ m_cfg[i][1]) : m_cfg[i][1];
      ok  = (m_mode == 2) ? (m_dir == 1) : (m_mode == 3) ? (m_dir == 0) : 1'b1;
      set = t && ok && (m_cnt == m_act[i]);
      clr = wr_en && (wr_addr == 4'd3) && wr_data[i];
      m_flag[i] = set || (m_flag[i] && !clr);
      nsh = (wr_en && wr_addr == 4'(4 + i)) ? int'(wr_data) : m_sh[i];
      if (!m_cfg[i][2] || u) m_act[i] = nsh;
      m_sh[i] = nsh;
      if (wr_en && wr_addr == 4'(8 + i)) m_cfg[i] = wr_data[3:0];
    end
    if (wr_en && wr_addr == 4'd0) begin
      m_mode = (wr_data[2:0] > 3'd4) ? 0 : int'(wr_data[2:0]);
      m_en = int'(wr_data[3]);
    end
    if (wr_en && wr_addr == 4'd1) m_per = int'(wr_data);
    if (wr_en && wr_addr == 4'd2) m_psc = int'(wr_data);
    m_pcnt = npc; m_cnt = ncnt; m_dir = ndir;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sync = 2'b00;
      model_reset();
    end else begin
      if (m_sync[1]) model_step();
      m_sync = {m_sync[0], 1'b1};
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all();
    string tag;
    chk(upd_evt == m_upd(), (m_mode <= 1) ? "R3 update pulse" : "R4 update pulse",
        int'(upd_evt), int'(m_upd()));
    for (int i = 0; i < 4; i++) begin
      if (!m_cfg[i][3])               tag = "R11 disabled pin";
      else if (m_sh[i] != m_act[i])   tag = "R10 preload pin";
      else if (m_cfg[i][0])           tag = "R6 rule-1 pin";
      else                            tag = "R5 rule-0 pin";
      chk(pwm_out[i] == m_pwm[i], tag, int'(pwm_out[i]), int'(m_pwm[i]));
      chk(cmp_flag[i] == m_flag[i], "R8 compare flag", int'(cmp_flag[i]), int'(m_flag[i]));
    end
    if (pair01) chk(pwm_out[0] != pwm_out[1], "R7 pair 0/1", int'(pwm_out[1]), int'(!pwm_out[0]));
    if (pair23) chk(pwm_out[2] != pwm_out[3], "R10 pair 2/3", int'(pwm_out[3]), int'(!pwm_out[2]));
  endtask

  task automatic cyc();
    @(negedge clk);
    check_all();
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = 16'(d);
    cyc();
    wr_en = 1'b0;
  endtask

  task automatic measure(input int exp, input string tag);
    int n;
    do cyc(); while (!upd_evt);
    n = 0;
    do begin cyc(); n++; end while (!upd_evt);
    chk(n == exp, tag, n, exp);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) cyc();
    // R1 reset state
    chk(pwm_out == 4'h0, "R1 pins after reset", int'(pwm_out), 0);
    chk(cmp_flag == 4'h0, "R1 flags after reset", int'(cmp_flag), 0);
    chk(upd_evt == 1'b0, "R1 update after reset", int'(upd_evt), 0);

    // up mode, complementary pair on channels 0/1
    wr(1, 9); wr(2, 0);
    wr(8, 4'b1000); wr(9, 4'b1010);
    wr(4, 4); wr(5, 4);
    wr(0, 8 | 0);
    cyc(); pair01 = 1;
    measure(10, "R3 up-mode interval");
    wr(0, 8 | 1);
    measure(10, "R3 down-mode interval");
    wr(0, 8 | 2);
    measure(9, "R4 center interval");
    wr(2, 3); wr(1, 4); wr(0, 8 | 0);
    measure(20, "R2 prescaled interval");
    wr(2, 0); wr(1, 9);

    // R9 set and clear in the same cycle
    wr(0, 8 | 4);
    while (!(m_tick() && m_cnt == m_act[0])) cyc();
    wr(3, 1);
    chk(cmp_flag[0] == 1'b1, "R9 set wins over clear", int'(cmp_flag[0]), 1);
    while (m_tick() && m_cnt == m_act[0]) cyc();
    wr(3, 1);
    chk(cmp_flag[0] == 1'b0, "R9 clear", int'(cmp_flag[0]), 0);

    // R10 preloaded pair on channels 2/3
    wr(10, 4'b1100); wr(11, 4'b1110);
    wr(6, 3); wr(7, 3);
    measure(9, "R4 center-C interval");
    cyc(); pair23 = 1;
    repeat (2) cyc();
    wr(6, 7);
    chk(m_act[2] == 3, "R10 shadow not yet active", m_act[2], 3);
    wr(7, 7);
    repeat (30) cyc();

    // R11 disabled, active-low channel sits high
    pair01 = 0;
    wr(9, 4'b0010);
    cyc();
    for (int k = 0; k < 20; k++) begin
      cyc();
      chk(pwm_out[1] == 1'b1, "R11 inactive level", int'(pwm_out[1]), 1);
    end

    // R8 / R5 / R6 random configurations
    pair23 = 0;
    for (int r = 0; r < 16; r++) begin
      int per;
      per = 3 + int'($urandom % 30);
      wr(1, per);
      wr(2, int'($urandom % 3));
      for (int i = 0; i < 4; i++) begin
        wr(8 + i, int'($urandom % 16));
        wr(4 + i, int'($urandom % (per + 2)));
      end
      wr(3, 15);
      wr(0, 8 | int'($urandom % 5));
      for (int k = 0; k < 250; k++) begin
        if (($urandom % 20) == 0) begin
          if ($urandom % 2) wr(3, int'($urandom % 16));
          else              wr(4 + int'($urandom % 4), int'($urandom % (per + 2)));
        end else begin
          cyc();
        end
      end
    end
    finish_run();
  end
endmodule